// File: doc/BRIEF.md
# DDR Read Burst Data-Out Sequencer

This is the memory-side logic that answers a decoded READ command with a double-data-rate output burst. Commands arrive already decoded, one per clock, together with a bank, a column and an auto-precharge flag. The sequencer holds each command for the programmed CAS latency. It then fetches one column pair per clock from a simple addressable source port. Every clock it drives a rise-edge word, a fall-edge word, a strobe level and an output enable.

The strobe framing follows fixed rules. A strobe-low preamble clock comes before the first pair. A strobe-low postamble clock follows the last pair, and after it the outputs float. A later READ, WRITE, BURST TERMINATE or PRECHARGE cuts the running burst on a pair boundary. A READ joins its data onto the earlier burst with no gap. A burst issued with auto precharge reports the end of its data with a one-clock pulse that carries the bank.

Top module: `ddr_rd_seq`

## Requirements
- R1: After reset, and in every clock where `oe_o` is low, `dqs_o`, `dq_rise_o` and `dq_fall_o` are all zero.
- R2: A READ (cmd_i = 0) sampled on edge E shows its first pair on the outputs after edge E+CL. CL is 2 when `cas_lat_i` equals 2 and 3 for any other value.
- R3: When no burst data occupies the clock before the first pair, that clock shows `oe_o`=1 and `dqs_o`=0 (preamble).
- R4: The clock after the last pair of a burst that no READ continues shows `oe_o`=1, `dqs_o`=0 and zero data (postamble). `oe_o` is low in the clock after that.
- R5: Each data clock shows `dqs_o`=1. `dq_rise_o` carries the source word of the even column and `dq_fall_o` the word of the next column. The burst length is 2, 4 or 8 elements for `bl_sel_i` = 0, 1, or 2 and 3. Columns advance upward and wrap inside the aligned burst-length block. Column bit 0 of a READ is ignored.
- R6: A READ issued x clocks after an earlier READ leaves x pairs of the earlier burst. Its own first pair follows in the very next clock, with no preamble and no postamble between the two.
- R7: A BURST TERMINATE (cmd_i = 2) or WRITE (cmd_i = 1) issued x clocks after a READ leaves x pairs, followed by a postamble.
- R8: A PRECHARGE (cmd_i = 3) x clocks after a READ leaves x pairs only when it names the burst's bank and that READ had auto precharge off. Otherwise the burst runs to full length.
- R9: A burst issued with `auto_pre_i`=1 raises `ap_done_o` for one clock, with `ap_bank_o` set to its bank, in the clock after its last pair. A burst without auto precharge never raises it.
- R10: When a READ's preamble clock falls on the postamble clock of the earlier burst, that single clock shows `oe_o`=1 and `dqs_o`=0. The output enable stays high from the earlier burst's data into the new burst's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is present this clock |
| cmd_i | input | 2 | Command code: 0 READ, 1 WRITE, 2 BURST TERMINATE, 3 PRECHARGE |
| bank_i | input | BANK_W | Bank of the command |
| col_i | input | COL_W | Start column of a READ |
| auto_pre_i | input | 1 | Auto precharge requested with the READ |
| cas_lat_i | input | 2 | CAS latency setting, 2 or 3 |
| bl_sel_i | input | 2 | Burst length select: 0 = 2, 1 = 4, else 8 |
| src_bank_o | output | BANK_W | Bank of the pair to fetch |
| src_col_o | output | COL_W | Even column of the pair to fetch |
| src_rise_i | input | DW | Source word at src_col_o, same clock |
| src_fall_i | input | DW | Source word at src_col_o + 1, same clock |
| dq_rise_o | output | DW | Rise-edge data word |
| dq_fall_o | output | DW | Fall-edge data word |
| dqs_o | output | 1 | Strobe level: 1 on data clocks, 0 on preamble and postamble |
| oe_o | output | 1 | Output enable, low means high impedance |
| ap_done_o | output | 1 | One-clock pulse: an auto-precharge burst has ended |
| ap_bank_o | output | BANK_W | Bank for ap_done_o |

## Verification
The postamble of one burst and the preamble of the next can fall in the same clock. The bench provokes this by issuing a second READ one clock after the point where it would concatenate. It then checks that the shared clock is strobe-low with the enable still high, and that the new data follows at once. The bench also makes a burst's last natural pair coincide with the start of a concatenated burst. It judges that pair by the exact column sequence, with no strobe-low clock between the two bursts.

// File: rtl/ddr_rd_pkg.sv
`timescale 1ns/1ps
package ddr_rd_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_BST   = 2'd2,
    CMD_PRE   = 2'd3
  } cmd_e;

  localparam int unsigned MAX_CL = 3;

  // element mask of the burst block; pairs left after first = mask >> 1
  function automatic logic [2:0] bl_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'b001;
      2'd1:    return 3'b011;
      default: return 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/ddr_cmd_pipe.sv
`timescale 1ns/1ps
module ddr_cmd_pipe #(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned COL_W  = 9,
  parameter int unsigned DEPTH  = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          v_i,
  input  logic [1:0]                    cmd_i,
  input  logic [BANK_W-1:0]             bank_i,
  input  logic [COL_W-1:0]              col_i,
  input  logic                          ap_i,
  output logic [DEPTH-1:0]              v_o,
  output logic [DEPTH-1:0][1:0]         cmd_o,
  output logic [DEPTH-1:0][BANK_W-1:0]  bank_o,
  output logic [DEPTH-1:0][COL_W-1:0]   col_o,
  output logic [DEPTH-1:0]              ap_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic              v_d, ap_d;
    logic [1:0]        cmd_d;
    logic [BANK_W-1:0] bank_d;
    logic [COL_W-1:0]  col_d;
    if (g == 0) begin : g_head
      assign v_d = v_i;      assign cmd_d = cmd_i; assign bank_d = bank_i;
      assign col_d = col_i;  assign ap_d = ap_i;
    end else begin : g_tail
      assign v_d = v_o[g-1];      assign cmd_d = cmd_o[g-1]; assign bank_d = bank_o[g-1];
      assign col_d = col_o[g-1];  assign ap_d = ap_o[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_o[g] <= 1'b0; cmd_o[g] <= '0; bank_o[g] <= '0; col_o[g] <= '0; ap_o[g] <= 1'b0;
      end else begin
        v_o[g] <= v_d; cmd_o[g] <= cmd_d; bank_o[g] <= bank_d; col_o[g] <= col_d; ap_o[g] <= ap_d;
      end
    end
  end
endmodule

// File: rtl/ddr_burst_ctrl.sv
`timescale 1ns/1ps
module ddr_burst_ctrl import ddr_rd_pkg::*; #(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned COL_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              e_v_i,
  input  cmd_e              e_cmd_i,
  input  logic [BANK_W-1:0] e_bank_i,
  input  logic [COL_W-1:0]  e_col_i,
  input  logic              e_ap_i,
  input  logic [1:0]        bl_sel_i,
  output logic              pair_v_o,
  output logic [BANK_W-1:0] src_bank_o,
  output logic [COL_W-1:0]  src_col_o,
  output logic              ap_done_o,
  output logic [BANK_W-1:0] ap_bank_o
);
  logic              act_q, act_n, ap_q, ap_n;
  logic [2:0]        rem_q, rem_n, mask_q, mask_n;
  logic [COL_W-1:0]  col_q, col_n, mask_ext;
  logic [BANK_W-1:0] bank_q, bank_n;
  logic              is_read, is_cut, ending;

  assign mask_ext = COL_W'(mask_q);

  always_comb begin
    is_read = e_v_i && (e_cmd_i == CMD_READ);
    is_cut  = e_v_i && act_q &&
              ((e_cmd_i == CMD_WRITE) || (e_cmd_i == CMD_BST) ||
               ((e_cmd_i == CMD_PRE) && (e_bank_i == bank_q) && !ap_q));
    act_n = act_q; rem_n = rem_q; mask_n = mask_q;
    col_n = col_q; bank_n = bank_q; ap_n = ap_q;
    if (is_read) begin
      act_n  = 1'b1;
      mask_n = bl_mask(bl_sel_i);
      rem_n  = {1'b0, mask_n[2:1]};
      col_n  = {e_col_i[COL_W-1:1], 1'b0};
      bank_n = e_bank_i;
      ap_n   = e_ap_i;
    end else if (is_cut) begin
      act_n = 1'b0;
    end else if (act_q && (rem_q != 3'd0)) begin
      rem_n = rem_q - 3'd1;
      col_n = (col_q & ~mask_ext) | ((col_q + COL_W'(2)) & mask_ext);
    end else begin
      act_n = 1'b0;
    end
    ending = act_q && (is_read || is_cut || (rem_q == 3'd0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; rem_q <= '0; mask_q <= '0; col_q <= '0;
      bank_q <= '0; ap_q <= 1'b0; ap_done_o <= 1'b0; ap_bank_o <= '0;
    end else begin
      act_q <= act_n; rem_q <= rem_n; mask_q <= mask_n; col_q <= col_n;
      bank_q <= bank_n; ap_q <= ap_n;
      ap_done_o <= ending && ap_q;
      ap_bank_o <= bank_q;
    end
  end

  assign pair_v_o   = act_n;
  assign src_bank_o = bank_n;
  assign src_col_o  = col_n;
endmodule

// File: rtl/ddr_dq_out.sv
`timescale 1ns/1ps
module ddr_dq_out #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pair_v_i,
  input  logic          pre_req_i,
  input  logic [DW-1:0] rise_i,
  input  logic [DW-1:0] fall_i,
  output logic [DW-1:0] dq_rise_o,
  output logic [DW-1:0] dq_fall_o,
  output logic          dqs_o,
  output logic          oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o <= 1'b0; dqs_o <= 1'b0; dq_rise_o <= '0; dq_fall_o <= '0;
    end else if (pair_v_i) begin
      oe_o <= 1'b1; dqs_o <= 1'b1; dq_rise_o <= rise_i; dq_fall_o <= fall_i;
    end else if (dqs_o || pre_req_i) begin
      // postamble after data, or preamble ahead of a READ; one state serves both
      oe_o <= 1'b1; dqs_o <= 1'b0; dq_rise_o <= '0; dq_fall_o <= '0;
    end else begin
      oe_o <= 1'b0; dqs_o <= 1'b0; dq_rise_o <= '0; dq_fall_o <= '0;
    end
  end
endmodule

// File: rtl/ddr_rd_seq.sv
`timescale 1ns/1ps
module ddr_rd_seq import ddr_rd_pkg::*; #(
  parameter int unsigned DW     = 16,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned COL_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              auto_pre_i,
  input  logic [1:0]        cas_lat_i,
  input  logic [1:0]        bl_sel_i,
  output logic [BANK_W-1:0] src_bank_o,
  output logic [COL_W-1:0]  src_col_o,
  input  logic [DW-1:0]     src_rise_i,
  input  logic [DW-1:0]     src_fall_i,
  output logic [DW-1:0]     dq_rise_o,
  output logic [DW-1:0]     dq_fall_o,
  output logic              dqs_o,
  output logic              oe_o,
  output logic              ap_done_o,
  output logic [BANK_W-1:0] ap_bank_o
);
  localparam int unsigned PD = MAX_CL;

  logic [PD-1:0]             p_v, p_ap;
  logic [PD-1:0][1:0]        p_cmd;
  logic [PD-1:0][BANK_W-1:0] p_bank;
  logic [PD-1:0][COL_W-1:0]  p_col;
  logic                      cl3, pre_req, pair_v;
  logic [1:0]                eff_idx, pre_idx;

  ddr_cmd_pipe #(.BANK_W(BANK_W), .COL_W(COL_W), .DEPTH(PD)) u_pipe (
    .clk_i, .rst_ni, .v_i(cmd_valid_i), .cmd_i, .bank_i, .col_i, .ap_i(auto_pre_i),
    .v_o(p_v), .cmd_o(p_cmd), .bank_o(p_bank), .col_o(p_col), .ap_o(p_ap)
  );

  // stage k holds a command sampled k+1 edges ago
  assign cl3     = (cas_lat_i != 2'd2);
  assign eff_idx = cl3 ? 2'd2 : 2'd1;
  assign pre_idx = cl3 ? 2'd1 : 2'd0;
  assign pre_req = p_v[pre_idx] && (cmd_e'(p_cmd[pre_idx]) == CMD_READ);

  ddr_burst_ctrl #(.BANK_W(BANK_W), .COL_W(COL_W)) u_ctrl (
    .clk_i, .rst_ni,
    .e_v_i(p_v[eff_idx]), .e_cmd_i(cmd_e'(p_cmd[eff_idx])), .e_bank_i(p_bank[eff_idx]),
    .e_col_i(p_col[eff_idx]), .e_ap_i(p_ap[eff_idx]), .bl_sel_i,
    .pair_v_o(pair_v), .src_bank_o, .src_col_o, .ap_done_o, .ap_bank_o
  );

  ddr_dq_out #(.DW(DW)) u_out (
    .clk_i, .rst_ni, .pair_v_i(pair_v), .pre_req_i(pre_req),
    .rise_i(src_rise_i), .fall_i(src_fall_i),
    .dq_rise_o, .dq_fall_o, .dqs_o, .oe_o
  );
endmodule

// File: rtl/ddr_rd_seq_chk.sv
`timescale 1ns/1ps
module ddr_rd_seq_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          oe_o,
  input logic          dqs_o,
  input logic [DW-1:0] dq_rise_o,
  input logic [DW-1:0] dq_fall_o,
  input logic          ap_done_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (!dqs_o && dq_rise_o == '0 && dq_fall_o == '0));
  a_r3_data_after_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dqs_o) |-> $past(oe_o));
  a_r3_open_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> !dqs_o);
  a_r4_post_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && dqs_o) |=> oe_o);
  a_r4_close_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> $past(!dqs_o));
  a_r9_ap_after_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_done_o |-> $past(oe_o && dqs_o));
endmodule

bind ddr_rd_seq ddr_rd_seq_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .oe_o(oe_o), .dqs_o(dqs_o),
  .dq_rise_o(dq_rise_o), .dq_fall_o(dq_fall_o), .ap_done_o(ap_done_o)
);

// File: tb/sim_ddr_rd_seq.sv
`timescale 1ns/1ps
module sim_ddr_rd_seq;
  localparam int DW = 16, BW = 2, CW = 9, LOGN = 2048;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0, auto_pre_i = 1'b0;
  logic [1:0] cmd_i = '0, cas_lat_i = 2'd2, bl_sel_i = 2'd1;
  logic [BW-1:0] bank_i = '0, src_bank_o, ap_bank_o;
  logic [CW-1:0] col_i = '0, src_col_o;
  logic [DW-1:0] src_rise_i, src_fall_i, dq_rise_o, dq_fall_o;
  logic dqs_o, oe_o, ap_done_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic          l_oe [LOGN], l_dqs [LOGN], l_apd [LOGN];
  logic [DW-1:0] l_r [LOGN], l_f [LOGN];
  logic [BW-1:0] l_apb [LOGN];

  always #2 clk_i = ~clk_i;

  ddr_rd_seq u0 (.*);

  function automatic logic [DW-1:0] fdat(int b, int c);
    return 16'h5000 | 16'((b << 9) | (c & 511));
  endfunction

  always_comb begin
    src_rise_i = fdat(int'(src_bank_o), int'(src_col_o));
    src_fall_i = fdat(int'(src_bank_o), int'(src_col_o) + 1);
  end

  always @(posedge clk_i) cyc++;
  always @(negedge clk_i) begin
    l_oe[cyc] = oe_o; l_dqs[cyc] = dqs_o; l_r[cyc] = dq_rise_o;
    l_f[cyc] = dq_fall_o; l_apd[cyc] = ap_done_o; l_apb[cyc] = ap_bank_o;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(int c, int b, int col, bit ap, output int e);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_i = 2'(c); bank_i = BW'(b); col_i = CW'(col); auto_pre_i = ap;
    e = cyc + 1;
  endtask

  task automatic idle(int k);
    repeat (k) begin @(negedge clk_i); cmd_valid_i = 1'b0; end
  endtask

  task automatic exp_burst(int e, int cl, int sel, int b, int c, int np, bit pre, bit post, string req);
    int bl = 2 << sel;
    int c0 = c & ~1;
    int base = c0 & ~(bl - 1);
    int t, cr, cf;
    if (pre) begin
      t = e + cl - 1;
      chk(req, "preamble oe", 32'(l_oe[t]), 1);
      chk(req, "preamble dqs", 32'(l_dqs[t]), 0);
    end
    for (int i = 0; i < np; i++) begin
      t = e + cl + i;
      cr = base | ((c0 + 2*i) & (bl - 1));
      cf = base | ((c0 + 2*i + 1) & (bl - 1));
      chk(req, $sformatf("pair %0d dqs", i), 32'(l_dqs[t]), 1);
      chk(req, $sformatf("pair %0d rise", i), 32'(l_r[t]), 32'(fdat(b, cr)));
      chk(req, $sformatf("pair %0d fall", i), 32'(l_f[t]), 32'(fdat(b, cf)));
    end
    if (post) begin
      t = e + cl + np;
      chk(req, "postamble oe", 32'(l_oe[t]), 1);
      chk(req, "postamble dqs", 32'(l_dqs[t]), 0);
      chk(req, "postamble data", 32'(l_r[t]), 0);
      chk(req, "float after postamble", 32'(l_oe[t+1]), 0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1", "reset oe", 32'(oe_o), 0);
    chk("R1", "reset dqs", 32'(dqs_o), 0);
    chk("R1", "reset data", 32'(dq_rise_o | dq_fall_o), 0);
    chk("R9", "reset ap_done", 32'(ap_done_o), 0);
  endtask

  task automatic t_single_cl2;
    int e;
    cas_lat_i = 2'd2; bl_sel_i = 2'd1;
    issue(0, 1, 6, 0, e); idle(12);
    chk("R2", "no data before latency", 32'(l_oe[e]), 0);
    exp_burst(e, 2, 1, 1, 6, 2, 1, 1, "R2 R3 R4 R5 wrap");
    chk("R9", "no ap pulse without auto precharge", 32'(l_apd[e+4]), 0);
  endtask

  task automatic t_single_cl3;
    int e;
    cas_lat_i = 2'd3; bl_sel_i = 2'd2;
    issue(0, 2, 2, 0, e); idle(14);
    chk("R2", "cl3 idle at cl-2", 32'(l_oe[e+1]), 0);
    exp_burst(e, 3, 2, 2, 2, 4, 1, 1, "R2 R5 cl3 bl8");
  endtask

  task automatic t_concat;
    int a, b;
    cas_lat_i = 2'd2; bl_sel_i = 2'd1;
    issue(0, 0, 0, 0, a); idle(1); issue(0, 3, 8, 0, b); idle(12);
    exp_burst(a, 2, 1, 0, 0, 2, 1, 0, "R6 first");
    exp_burst(b, 2, 1, 3, 8, 2, 0, 1, "R6 second");
  endtask

  task automatic t_cut_by_read;
    int a, b;
    cas_lat_i = 2'd2; bl_sel_i = 2'd2;
    issue(0, 1, 0, 0, a); issue(0, 1, 3, 0, b); idle(14);
    exp_burst(a, 2, 2, 1, 0, 1, 1, 0, "R6 cut");
    exp_burst(b, 2, 2, 1, 3, 4, 0, 1, "R5 col bit0 ignored");
  endtask

  task automatic t_bst_write;
    int a, x;
    cas_lat_i = 2'd3; bl_sel_i = 2'd2;
    issue(0, 0, 0, 0, a); idle(1); issue(2, 0, 0, 0, x); idle(14);
    exp_burst(a, 3, 2, 0, 0, 2, 1, 1, "R7 terminate");
    cas_lat_i = 2'd2;
    issue(0, 2, 4, 0, a); idle(2); issue(1, 1, 0, 0, x); idle(14);
    exp_burst(a, 2, 2, 2, 4, 3, 1, 1, "R7 write");
  endtask

  task automatic t_precharge;
    int a, x;
    cas_lat_i = 2'd2; bl_sel_i = 2'd2;
    issue(0, 2, 0, 0, a); issue(3, 2, 0, 0, x); idle(14);
    exp_burst(a, 2, 2, 2, 0, 1, 1, 1, "R8 same bank");
    issue(0, 2, 0, 0, a); issue(3, 1, 0, 0, x); idle(14);
    exp_burst(a, 2, 2, 2, 0, 4, 1, 1, "R8 other bank ignored");
    bl_sel_i = 2'd1;
    issue(0, 3, 4, 1, a); issue(3, 3, 0, 0, x); idle(14);
    exp_burst(a, 2, 1, 3, 4, 2, 1, 1, "R8 auto precharge ignores");
    chk("R9", "no pulse on last pair", 32'(l_apd[a+3]), 0);
    chk("R9", "ap pulse", 32'(l_apd[a+4]), 1);
    chk("R9", "ap bank", 32'(l_apb[a+4]), 3);
    chk("R9", "ap pulse single", 32'(l_apd[a+5]), 0);
  endtask

  task automatic t_shared_edge;
    int a, b;
    cas_lat_i = 2'd2; bl_sel_i = 2'd1;
    issue(0, 1, 2, 0, a); idle(2); issue(0, 2, 0, 0, b); idle(12);
    exp_burst(a, 2, 1, 1, 2, 2, 1, 0, "R10 first");
    chk("R10", "shared clock oe", 32'(l_oe[a+4]), 1);
    chk("R10", "shared clock dqs", 32'(l_dqs[a+4]), 0);
    exp_burst(b, 2, 1, 2, 0, 2, 1, 1, "R10 second");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung, expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_single_cl2;
    t_single_cl3;
    t_concat;
    t_cut_by_read;
    t_bst_write;
    t_precharge;
    t_shared_edge;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule